// File: doc/BRIEF.md
# Square Tone Channel with Decibel Attenuator

This block is one tone voice of a simple sound generator. A 10-bit half-period counter advances only on a shared prescale strobe that the surrounding design asserts once every 16 input clocks. Each time the counter runs out, it reloads from the period input and flips a square-wave flip-flop. With the strobe at one in sixteen clocks, the square wave runs at clock / (32 × period).

A 4-bit attenuation code sets the amplitude of the square wave. Each bit of the code adds a fixed number of decibels, and the all-ones code silences the channel. The amplitude is taken from a table of 16 levels. The table is worked out at elaboration time in 2 dB steps, starting from full scale. The raw flip-flop bit is also brought out every cycle, so that a neighbouring noise source can use this channel as its shift clock.

Top module: `sqtone_chan`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first strobe, `sq_o` is 0 and `amp_o` is 0. The counter is cleared by reset, so the first strobe after reset reloads it.
- R2: When `tick_i` is low, neither the counter nor `sq_o` changes, whatever `period_i` does.
- R3: For a period n ≥ 2, each level of `sq_o` lasts exactly n strobes. With a strobe every 16 clocks, that is 16·n clocks per half-period.
- R4: A borrow occurs on a strobe that finds the counter at 0 or 1. The borrow reloads the counter with `period_i` and, for n ≥ 2, inverts `sq_o`.
- R5: `period_i` is read only at a borrow. A change in the middle of a half-period does not shorten or stretch that half-period. It takes effect from the next reload.
- R6: A borrow that sees a period of 0 or 1 sets `sq_o` to 1. While such a period is applied, `sq_o` stays at 1.
- R7: Each `atten_i` bit adds a weight: bit 0 adds 2 dB, bit 1 adds 4 dB, bit 2 adds 8 dB and bit 3 adds 16 dB. The code value therefore counts 2 dB steps. The level for code 0 is 2^AMP_W − 1. The level for code k is floor(level(k−1) · 813 / 1024), a step of about 0.794. Code 15 (binary 1111) gives level 0.
- R8: `amp_o` is a register. On each clock it takes the level for the present `atten_i` if the flip-flop is 1 before that edge, and 0 if it is 0.
- R9: `sq_o` is the flip-flop itself. It goes out with no extra register stage and is valid on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescale strobe, one clock wide, nominally once per 16 clocks |
| period_i | input | 10 | Half-period length in strobes |
| atten_i | input | 4 | Attenuation code, 2 dB per unit, 1111 = silent |
| sq_o | output | 1 | Raw square-wave flip-flop |
| amp_o | output | 16 | Unsigned amplitude sample |

## Verification
A strobe that is high at a clock edge changes `sq_o` at that edge. `sq_o` is therefore sampled at the falling edge that follows. `amp_o` trails `sq_o` by one further edge, and it trails a change of `atten_i` by one edge. The bench drives all inputs on falling edges. It advances its reference model at each rising edge, from the inputs held at that edge, and compares both outputs at the next falling edge. Half-period checks count falling edges between observed transitions of `sq_o`, so the latency of the flip-flop cancels out.

// File: rtl/sqtone_pkg.sv
package sqtone_pkg;

  localparam int unsigned STEP_NUM   = 813;
  localparam int unsigned STEP_SHIFT = 10;

  function automatic longint unsigned level_for(input longint unsigned full,
                                                input int unsigned code,
                                                input int unsigned silent_code);
    longint unsigned v;
    v = full;
    if (code == silent_code) return 64'd0;
    for (int i = 0; i < 64; i++) begin
      if (i < int'(code)) v = (v * STEP_NUM) >> STEP_SHIFT;
    end
    return v;
  endfunction

  function automatic logic flat_period(input int unsigned p);
    return (p <= 1);
  endfunction

endpackage

// File: rtl/sqtone_divider.sv
module sqtone_divider import sqtone_pkg::*; #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             sq_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             sq_q;
  logic             borrow;
  logic             flat;

  assign borrow = tick_i && (cnt_q <= CNT_W'(1));
  assign flat   = flat_period(int'(period_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sq_q  <= 1'b0;
    end else if (borrow) begin
      cnt_q <= period_i;
      sq_q  <= flat ? 1'b1 : ~sq_q;
    end else if (tick_i) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign sq_o = sq_q;

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> ($stable(cnt_q) && $stable(sq_q)));

  assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !borrow) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    borrow |=> (cnt_q == $past(period_i)));

  assert_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (borrow && (period_i > CNT_W'(1))) |=> (sq_q != $past(sq_q)));

  assert_flat_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (borrow && (period_i <= CNT_W'(1))) |=> sq_q);

endmodule

// File: rtl/sqtone_level.sv
module sqtone_level import sqtone_pkg::*; #(
  parameter int ATT_W = 4,
  parameter int AMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sq_i,
  input  logic [ATT_W-1:0] atten_i,
  output logic [AMP_W-1:0] amp_o
);

  localparam int unsigned     LVLS   = 1 << ATT_W;
  localparam longint unsigned FULL   = (64'd1 << AMP_W) - 64'd1;
  localparam int unsigned     SILENT = LVLS - 1;

  logic [AMP_W-1:0] lut [LVLS];
  logic [AMP_W-1:0] amp_q;

  for (genvar g = 0; g < LVLS; g++) begin : g_lut
    assign lut[g] = AMP_W'(level_for(FULL, g, SILENT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) amp_q <= '0;
    else        amp_q <= sq_i ? lut[atten_i] : '0;
  end

  assign amp_o = amp_q;

  assert_silent_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (atten_i == ATT_W'(SILENT)) |=> (amp_q == '0));

  assert_full_scale_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_i && atten_i == '0) |=> (amp_q == AMP_W'(FULL)));

  assert_low_gives_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sq_i |=> (amp_q == '0));

endmodule

// File: rtl/sqtone_chan.sv
module sqtone_chan #(
  parameter int CNT_W = 10,
  parameter int ATT_W = 4,
  parameter int AMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [ATT_W-1:0] atten_i,
  output logic             sq_o,
  output logic [AMP_W-1:0] amp_o
);

  logic sq_raw;

  sqtone_divider #(.CNT_W(CNT_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .period_i (period_i),
    .sq_o     (sq_raw)
  );

  sqtone_level #(.ATT_W(ATT_W), .AMP_W(AMP_W)) u_lvl (
    .clk     (clk),
    .rst_n   (rst_n),
    .sq_i    (sq_raw),
    .atten_i (atten_i),
    .amp_o   (amp_o)
  );

  assign sq_o = sq_raw;

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!rst_n) && !$past(tick_i)) |-> (!sq_o && amp_o == '0));

  assert_amp_tracks_sq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (amp_o != '0) |-> $past(sq_o));

endmodule

// File: tb/sqtone_chan_tb.sv
module sqtone_chan_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic [9:0]  period_i = 10'd2;
  logic [3:0]  atten_i = 4'd0;
  logic        sq_o;
  logic [15:0] amp_o;

  int tests = 0;
  int failed = 0;
  bit tick_run = 0;
  int pre = 0;
  int cyc = 0;
  int last_edge = 0;
  logic prev_sq = 1'b0;
  int gaps[$];

  int  m_cnt = 0;
  bit  m_sq = 0;
  longint m_amp = 0;
  longint tbl [16];

  always #4 clk = ~clk;

  sqtone_chan u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .period_i(period_i),
    .atten_i(atten_i), .sq_o(sq_o), .amp_o(amp_o)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) begin
      @(negedge clk);
      tick_i = tick_run && (pre == 15);
      if (tick_run) pre = (pre + 1) % 16;
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  endtask

  // attenuation levels in dB steps: each step scales by 813/1024
  initial begin
    longint acc;
    acc = 65535;
    for (int k = 0; k < 16; k++) begin
      tbl[k] = (k == 15) ? 0 : acc;
      acc = (acc * 813) / 1024;
    end
  end

  // behavioural reference, advanced at each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_sq = 0; m_amp = 0;
    end else begin
      m_amp = m_sq ? tbl[atten_i] : 0;
      if (tick_i) begin
        if (m_cnt <= 1) begin
          m_cnt = period_i;
          m_sq  = (period_i <= 1) ? 1'b1 : !m_sq;
        end else begin
          m_cnt = m_cnt - 1;
        end
      end
    end
  end

  // per-cycle comparison and transition log
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R9", "sq_o vs model (R4)", sq_o, m_sq);
      chk("R8", "amp_o vs model", amp_o, m_amp);
      if (sq_o !== prev_sq) begin
        gaps.push_back(cyc - last_edge);
        last_edge = cyc;
      end
    end
    prev_sq = sq_o;
  end

  initial begin
    #(8 * 150000);
    failed++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    summary();
  end

  initial begin
    int guard;
    int bad;
    cycles(3);
    chk("R1", "sq_o in reset", sq_o, 0);
    chk("R1", "amp_o in reset", amp_o, 0);
    rst_n = 1'b1;
    cycles(5);
    chk("R1", "sq_o after release", sq_o, 0);
    chk("R1", "amp_o after release", amp_o, 0);

    // R3: half period of 5 strobes = 80 clocks
    period_i = 10'd5;
    tick_run = 1;
    cycles(200);
    gaps.delete();
    guard = 0;
    while (gaps.size() < 3 && guard < 1000) begin cycles(1); guard++; end
    for (int i = 0; i < 3; i++) chk("R3", "half period clocks", gaps[i], 80);

    // R5: period change mid half-period waits for reload
    period_i = 10'd40;
    guard = 0;
    gaps.delete();
    while (gaps.size() < 1 && guard < 1000) begin cycles(1); guard++; end
    gaps.delete();
    cycles(100);
    period_i = 10'd3;
    guard = 0;
    while (gaps.size() < 2 && guard < 2000) begin cycles(1); guard++; end
    chk("R5", "half period before reload", gaps[0], 640);
    chk("R5", "half period after reload", gaps[1], 48);

    // R2: strobe held low freezes everything
    tick_run = 0;
    cycles(2);
    gaps.delete();
    period_i = 10'd9;
    cycles(150);
    chk("R2", "transitions without strobe", gaps.size(), 0);
    tick_run = 1;

    // R6: period 1 and period 0 hold the output high
    period_i = 10'd1;
    cycles(100);
    bad = 0;
    for (int i = 0; i < 200; i++) begin cycles(1); if (sq_o !== 1'b1) bad++; end
    chk("R6", "low cycles with period 1", bad, 0);
    period_i = 10'd0;
    bad = 0;
    for (int i = 0; i < 200; i++) begin cycles(1); if (sq_o !== 1'b1) bad++; end
    chk("R6", "low cycles with period 0", bad, 0);

    // R7: every attenuation code with the output held high
    for (int k = 0; k < 16; k++) begin
      atten_i = 4'(k);
      cycles(1);
      chk("R7", $sformatf("level for code %0d", k), amp_o, tbl[k]);
    end
    chk("R7", "code 0 full scale", tbl[0], 65535);

    // R8: low half gives zero amplitude
    atten_i = 4'd2;
    period_i = 10'd6;
    guard = 0;
    while (sq_o !== 1'b0 && guard < 500) begin cycles(1); guard++; end
    cycles(1);
    chk("R8", "amp while low", amp_o, 0);
    cycles(300);

    summary();
  end

endmodule